// File: doc/BRIEF.md
# Stereo One-Bit Audio Converter Front End

This block sits between a register bus and a pair of one-bit audio outputs. Software places a left and a right sample into one 32-bit sample register with a single write. The converter clock runs at 256 times the audio sample rate. A period counter marks the end of each 256-cycle sample period. At that boundary the block copies the register into a holding pair. The holding pair feeds two first-order sigma-delta modulators, one for each channel, and each modulator produces a one-bit pulse-density stream.

Two status bits tell software how the stream is going. The ready bit shows that the held pair has just been refreshed and that the next pair may be written. The underrun bit is sticky. It records that a period boundary arrived with no new write, in which case the previous pair plays again. Each status bit has its own enable input, and together they drive a level interrupt. While the enable input is low, nothing is timed and nothing is flagged.

Top module: `stereo_bsdac`

## Requirements
- R1: After reset, `tx_ready`, `underrun`, `irq`, `bit_l` and `bit_r` are all 0.
- R2: While `enable` is 0, no period boundary occurs. `tx_ready` and `underrun` do not get set, and both bit outputs stay 0.
- R3: Once `enable` is 1, a period boundary occurs on every 256th rising clock edge. The first one is the 256th edge with `enable` high. Each boundary sets `tx_ready`, unless a sample write is taken at that same edge.
- R4: A sample write (`sdr_wr` high at a rising edge) clears `tx_ready` at that edge.
- R5: The left sample is the two's-complement value in `sdr_wdata[15:0]`. The right sample is the two's-complement value in `sdr_wdata[31:16]`. One write loads both samples, and a boundary copies both into the holding pair.
- R6: Each channel converts its held sample to offset binary by inverting bit 15. It adds that value to a 16-bit accumulator on every enabled cycle and outputs the registered carry. When the offset value is a multiple of 256 and the held sample stays constant, the outputs over any 256 consecutive cycles contain exactly offset/256 ones.
- R7: A boundary with no sample write since the previous boundary sets `underrun`. The held pair is then repeated unchanged.
- R8: `underrun` stays set until `urun_clr` is high at a rising edge. A new underrun in that same cycle takes priority over the clear.
- R9: `irq` equals (`tx_ready` AND `ie_ready`) OR (`underrun` AND `ie_urun`), as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable |
| sdr_wr | input | 1 | Sample register write strobe |
| sdr_wdata | input | 32 | Sample pair: right in 31:16, left in 15:0 |
| urun_clr | input | 1 | Write-one-to-clear of the underrun bit |
| ie_ready | input | 1 | Interrupt enable for ready |
| ie_urun | input | 1 | Interrupt enable for underrun |
| bit_l | output | 1 | Left one-bit stream |
| bit_r | output | 1 | Right one-bit stream |
| tx_ready | output | 1 | Next pair may be written |
| underrun | output | 1 | Sticky missed-write flag |
| irq | output | 1 | Level interrupt |

## Verification
If the period counter runs off its count, `tx_ready` rises on an edge other than the 256th, or `underrun` appears one period early or late, and the bench sees this within one sample period. If the holding pair is wired to the wrong field or swaps the channels, the ones count of a 256-cycle window is wrong on the very first period after the pair is loaded. The windows use asymmetric left/right pairs, so a swap is detected. If the accumulator or the offset conversion is wrong, the exact ones count for a multiple-of-256 offset is off within the same period.

// File: rtl/bsdac_pkg.sv
package bsdac_pkg;
  localparam int SAMPLE_W = 16;
  localparam int N_CH     = 2;

  typedef logic [SAMPLE_W-1:0] sample_t;

  // signed sample to offset binary: flip the sign bit
  function automatic sample_t to_offset(input sample_t s);
    return s ^ (sample_t'(1) << (SAMPLE_W-1));
  endfunction

  // one accumulation step: returns {carry, new accumulator}
  function automatic logic [SAMPLE_W:0] sdm_step(input sample_t acc, input sample_t off);
    return {1'b0, acc} + {1'b0, off};
  endfunction
endpackage

// File: rtl/bsdac_period_timer.sv
module bsdac_period_timer #(
  parameter int OSR = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic boundary
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR-1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!enable)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign boundary = enable && (cnt_q == LAST);

  AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !boundary); // R2
endmodule

// File: rtl/bsdac_status.sv
module bsdac_status (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic sdr_wr,
  input  logic urun_clr,
  output logic tx_ready,
  output logic underrun
);
  logic written_q;
  logic miss;

  assign miss = boundary && !written_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= 1'b0;
      tx_ready  <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (sdr_wr)        written_q <= 1'b1;
      else if (boundary) written_q <= 1'b0;

      if (sdr_wr)        tx_ready <= 1'b0;
      else if (boundary) tx_ready <= 1'b1;

      if (miss)          underrun <= 1'b1;
      else if (urun_clr) underrun <= 1'b0;
    end
  end

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !sdr_wr |=> tx_ready); // R3
  AST_READY_CLR_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    sdr_wr |=> !tx_ready); // R4
  AST_URUN_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !written_q |=> underrun); // R7
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !urun_clr |=> underrun); // R8
endmodule

// File: rtl/bsdac_sdm.sv
module bsdac_sdm
  import bsdac_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  sample_t sample,
  output logic    bit_o
);
  sample_t           acc_q;
  logic [SAMPLE_W:0] step;

  assign step = sdm_step(acc_q, to_offset(sample));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_o <= 1'b0;
    end else if (!enable) begin
      acc_q <= '0;
      bit_o <= 1'b0;
    end else begin
      acc_q <= step[SAMPLE_W-1:0];
      bit_o <= step[SAMPLE_W];
    end
  end

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bit_o); // R2
endmodule

// File: rtl/stereo_bsdac.sv
module stereo_bsdac
  import bsdac_pkg::*;
#(
  parameter int OSR = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        sdr_wr,
  input  logic [31:0] sdr_wdata,
  input  logic        urun_clr,
  input  logic        ie_ready,
  input  logic        ie_urun,
  output logic        bit_l,
  output logic        bit_r,
  output logic        tx_ready,
  output logic        underrun,
  output logic        irq
);
  localparam int REG_W = SAMPLE_W * N_CH;

  logic [N_CH-1:0][SAMPLE_W-1:0] sdr_q;
  logic [N_CH-1:0][SAMPLE_W-1:0] hold_q;
  logic [N_CH-1:0]               bits;
  logic                          boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sdr_q <= '0;
    else if (sdr_wr) sdr_q <= sdr_wdata[REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (boundary) hold_q <= sdr_q;
  end

  bsdac_period_timer #(.OSR(OSR)) timer_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .boundary(boundary)
  );

  bsdac_status status_i (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .sdr_wr(sdr_wr),
    .urun_clr(urun_clr), .tx_ready(tx_ready), .underrun(underrun)
  );

  // channel 0 = left (bits 15:0), channel 1 = right (bits 31:16)
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    bsdac_sdm sdm_i (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .sample(hold_q[ch]), .bit_o(bits[ch])
    );
  end

  assign bit_l = bits[0];
  assign bit_r = bits[1];
  assign irq   = (tx_ready && ie_ready) || (underrun && ie_urun);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(hold_q)); // R7
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> hold_q == $past(sdr_q)); // R5
endmodule

// File: tb/stereo_bsdac_tb.sv
module stereo_bsdac_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, sdr_wr = 1'b0, urun_clr = 1'b0, ie_ready = 1'b0, ie_urun = 1'b0;
  logic [31:0] sdr_wdata = '0;
  logic bit_l, bit_r, tx_ready, underrun, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  stereo_bsdac dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sdr_wr(sdr_wr),
    .sdr_wdata(sdr_wdata), .urun_clr(urun_clr), .ie_ready(ie_ready),
    .ie_urun(ie_urun), .bit_l(bit_l), .bit_r(bit_r), .tx_ready(tx_ready),
    .underrun(underrun), .irq(irq)
  );

  // pair table: {right, left}, all multiples of 256
  localparam logic [31:0] VEC [6] = '{
    32'h0000_0000, 32'h8000_7F00, 32'hC000_4000,
    32'h4000_C000, 32'h1200_8000, 32'h7F00_0000
  };

  // expected ones per 256 cycles: unsigned view of sample + 32768, divided by 256
  function automatic int ones_expected(input logic [15:0] s);
    int v;
    v = int'($signed(s)) + 32768;
    return v / 256;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_pair(input logic [31:0] d);
    @(negedge clk);
    sdr_wr = 1'b1; sdr_wdata = d;
    @(negedge clk);
    sdr_wr = 1'b0;
  endtask

  task automatic count_window(output int cl, output int cr);
    cl = 0; cr = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cl += int'(bit_l); cr += int'(bit_r);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cl, cr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_ready", int'(tx_ready), 0);
    check("R1 underrun", int'(underrun), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 bits", int'({bit_r, bit_l}), 0);
    rst_n = 1'b1;

    // R2 disabled: writes and time pass, nothing happens
    write_pair(32'h7F00_7F00);
    repeat (600) @(negedge clk);
    check("R2 tx_ready", int'(tx_ready), 0);
    check("R2 underrun", int'(underrun), 0);
    check("R2 bits", int'({bit_r, bit_l}), 0);

    // R3 / R7 exact period timing, from the first enabled edge
    @(negedge clk);
    enable = 1'b1; sdr_wr = 1'b1; sdr_wdata = 32'h4000_C000;
    @(negedge clk);        // edge 1
    sdr_wr = 1'b0;
    repeat (254) @(negedge clk);  // edge 255
    check("R3 ready before first boundary", int'(tx_ready), 0);
    @(negedge clk);        // edge 256
    check("R3 ready at first boundary", int'(tx_ready), 1);
    check("R7 no underrun after write", int'(underrun), 0);
    repeat (255) @(negedge clk);  // edge 511
    check("R7 underrun before second boundary", int'(underrun), 0);
    @(negedge clk);        // edge 512
    check("R7 underrun at missed boundary", int'(underrun), 1);
    // R7 repeated pair keeps playing
    count_window(cl, cr);
    check("R7 repeated left", cl, ones_expected(16'hC000));
    check("R7 repeated right", cr, ones_expected(16'h4000));

    // R9 interrupt combinations (ready=1, underrun=1 here)
    @(negedge clk);
    check("R9 both enables off", int'(irq), 0);
    ie_urun = 1'b1; #1;
    check("R9 underrun source", int'(irq), 1);
    ie_urun = 1'b0; ie_ready = 1'b1; #1;
    check("R9 ready source", int'(irq), 1);
    ie_ready = 1'b0;

    // R8 sticky across writes, cleared by urun_clr
    write_pair(32'h0000_0000);
    check("R8 sticky after write", int'(underrun), 1);
    check("R4 ready cleared by write", int'(tx_ready), 0);
    @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    check("R8 cleared", int'(underrun), 0);
    ie_urun = 1'b1; #1;
    check("R9 cleared underrun source", int'(irq), 0);
    ie_urun = 1'b0;

    // R5 / R6 vector walk
    foreach (VEC[k]) begin
      write_pair(VEC[k]);
      check("R4 ready low after write", int'(tx_ready), 0);
      while (!tx_ready) @(negedge clk);
      count_window(cl, cr);
      check("R5 R6 left count", cl, ones_expected(VEC[k][15:0]));
      check("R5 R6 right count", cr, ones_expected(VEC[k][31:16]));
    end

    // R2 disabling drops the streams
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 bits after disable", int'({bit_r, bit_l}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule